// File: doc/BRIEF.md
# Instruction TLB with Fill-Time No-Execute Check

This block is a first-level translation cache for instruction fetch. It maps the virtual page number of a fetch address to a physical frame for 4 KB pages and hands the fetch unit the physical address, a hit flag and an execute-denied flag one clock after the request. Entries are loaded through a fill port that carries a 64-bit page table entry from a page walker or a larger second-level cache. A single flush input empties the whole structure.

Execute permission is not evaluated on each fetch. When an entry is filled, the top bit of the page table entry is captured as a per-entry poison bit, and the user/supervisor bit is stored next to it. A lookup that hits a poisoned entry, or a user-mode fetch that hits a supervisor page, reports denied. The fault output, together with the faulting virtual address, is raised only when the fetch is marked as committed (non-speculative). A speculative fetch that runs into a forbidden page gets the deny flag and no trap, so wrong-path fetches never fault.

The storage is 8 sets of 8 ways. The set is chosen by the low three bits of the virtual page number. Within a set, an invalid way is used first. When the set is full, the victim comes from a tree pseudo-LRU.

Top module: `itlb_nx_top`

## Requirements
- R1: A lookup that hits returns `xlat_hit`=1 and `xlat_pa` = {entry bits 51:12, fetch_va[11:0]}, with `xlat_valid` high exactly one cycle after `fetch_valid`.
- R2: A lookup whose page is not held returns `xlat_hit`=0, `xlat_deny`=0 and `xlat_fault`=0.
- R3: When bit 63 of the filled entry is 1, every later hit on that entry reports `xlat_deny`=1, whatever the privilege of the fetch.
- R4: `xlat_fault` is 1 only for a denied hit with `fetch_commit`=1. With `fetch_commit`=0 the same hit reports `xlat_deny`=1 and `xlat_fault`=0.
- R5: When `xlat_fault` is 1, `fault_va` equals the full virtual address of that lookup.
- R6: When bit 2 of the filled entry is 0 (supervisor page), a hit with `fetch_user`=1 is denied and a hit with `fetch_user`=0 is allowed, as long as bit 63 is 0.
- R7: A fill whose entry has bit 0 (present) equal to 0 is not stored, and `fill_nopresent` is 1 in the cycle after that fill. A fill with bit 0 equal to 1 leaves `fill_nopresent` at 0.
- R8: `flush` invalidates every entry in one cycle. A fill in the same cycle as `flush` is dropped.
- R9: A fill to a virtual page that is already held overwrites that entry, so later lookups return the new frame and the new permissions.
- R10: A fill goes to an invalid way of its set when one exists. In a full set, the fill replaces the tree pseudo-LRU victim, and the tree is updated on every hit and every fill.
- R11: After reset all entries are invalid and `xlat_valid`, `xlat_fault` and `fill_nopresent` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| fill_valid | input | 1 | Fill request strobe |
| fill_vpn | input | 36 | Virtual page number being filled |
| fill_pte | input | 64 | Page table entry for the fill |
| fill_nopresent | output | 1 | Previous fill was dropped because its present bit was 0 |
| fetch_valid | input | 1 | Lookup request strobe |
| fetch_va | input | 48 | Fetch virtual address |
| fetch_user | input | 1 | Fetch runs in user mode |
| fetch_commit | input | 1 | Fetch is non-speculative |
| xlat_valid | output | 1 | Lookup result valid |
| xlat_hit | output | 1 | Translation found |
| xlat_pa | output | 52 | Physical address (zero on a miss) |
| xlat_deny | output | 1 | Execution from this page is forbidden |
| xlat_fault | output | 1 | Execute fault for a committed fetch |
| fault_va | output | 48 | Virtual address of the faulting fetch |

## Verification
The assertions assume that the fill path is the only way tags get into the array, so at most one way of a set can match a fetch. They also assume that `flush` may come in any cycle, including during reset. The stimulus keeps this true by sending every fill through the port, which probes for an existing match before it picks a way. It includes a deliberate refill of a page that is already held and a flush that collides with a fill. The replacement scenario runs right after a flush, so the order in which ways fill, and the victims that follow, are determined by the fill and hit sequence alone.

// File: rtl/itlb_nx_pkg.sv
package itlb_nx_pkg;
  localparam int PTE_W    = 64;
  localparam int NX_BIT   = 63;
  localparam int US_BIT   = 2;
  localparam int P_BIT    = 0;
  localparam int PFN_LO   = 12;
  localparam int PFN_HI   = 51;
  localparam int PFN_W    = PFN_HI - PFN_LO + 1;
  localparam int OFF_W    = 12;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic             user_ok;
    logic             nx_poison;
  } itlb_meta_t;
endpackage

// File: rtl/itlb_pte_decode.sv
module itlb_pte_decode
  import itlb_nx_pkg::*;
(
  input  logic [PTE_W-1:0] pte,
  output logic             present,
  output itlb_meta_t       meta
);
  // Permission is sampled here once, at insertion time
  always_comb begin
    present        = pte[P_BIT];
    meta.pfn       = pte[PFN_HI:PFN_LO];
    meta.user_ok   = pte[US_BIT];
    meta.nx_poison = pte[NX_BIT];
  end
endmodule

// File: rtl/itlb_plru.sv
module itlb_plru #(
  parameter int WAYS = 8,
  parameter int SETS = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     hit_en,
  input  logic [$clog2(SETS)-1:0]  hit_idx,
  input  logic [$clog2(WAYS)-1:0]  hit_way,
  input  logic                     fill_en,
  input  logic [$clog2(SETS)-1:0]  fill_idx,
  input  logic [$clog2(WAYS)-1:0]  fill_way,
  output logic [$clog2(WAYS)-1:0]  victim
);
  localparam int NODES = WAYS - 1;
  localparam int LW    = $clog2(WAYS);
  localparam int IW    = $clog2(SETS);

  logic [NODES-1:0] tree_q [SETS];

  // Heap-ordered tree: node n (1-based) has children 2n and 2n+1.
  // A node bit of 0 steers the victim search to the left child.
  function automatic logic [NODES-1:0] touch(input logic [NODES-1:0] t,
                                             input logic [LW-1:0] w);
    logic [NODES-1:0] r;
    int n;
    r = t;
    n = int'(w) + WAYS;
    for (int l = 0; l < LW; l++) begin
      r[(n / 2) - 1] = (n % 2 == 0);
      n = n / 2;
    end
    return r;
  endfunction

  function automatic logic [LW-1:0] pick(input logic [NODES-1:0] t);
    int n;
    n = 1;
    for (int l = 0; l < LW; l++) begin
      n = 2 * n + (t[n - 1] ? 1 : 0);
    end
    return LW'(n - WAYS);
  endfunction

  assign victim = pick(tree_q[fill_idx]);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        if (fill_en && fill_idx == IW'(s))
          tree_q[s] <= touch(tree_q[s], fill_way);
        else if (hit_en && hit_idx == IW'(s))
          tree_q[s] <= touch(tree_q[s], hit_way);
      end
    end
  end
endmodule

// File: rtl/itlb_way_store.sv
module itlb_way_store
  import itlb_nx_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int TAG_W = 33
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic                     we,
  input  logic [$clog2(SETS)-1:0]  wr_idx,
  input  logic [TAG_W-1:0]         wr_tag,
  input  itlb_meta_t               wr_meta,
  input  logic [$clog2(SETS)-1:0]  rd_idx,
  input  logic [TAG_W-1:0]         rd_tag,
  output logic                     rd_hit,
  output itlb_meta_t               rd_meta,
  output logic                     pr_match,
  output logic                     pr_valid
);
  logic [SETS-1:0] valid_q;
  logic [TAG_W-1:0] tag_mem  [SETS];
  itlb_meta_t       meta_mem [SETS];

  // Valid bits live in flops so a flush clears them in one cycle
  always_ff @(posedge clk) begin
    if (rst || flush) valid_q <= '0;
    else if (we)      valid_q[wr_idx] <= 1'b1;
  end

  // Tag and payload: no reset, single write port (distributed RAM)
  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[wr_idx]  <= wr_tag;
      meta_mem[wr_idx] <= wr_meta;
    end
  end

  assign rd_hit   = valid_q[rd_idx] && (tag_mem[rd_idx] == rd_tag);
  assign rd_meta  = meta_mem[rd_idx];
  assign pr_valid = valid_q[wr_idx];
  assign pr_match = pr_valid && (tag_mem[wr_idx] == wr_tag);

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (rst)
    $past(flush) |-> (valid_q == '0))
    else $error("flush left a valid entry");
endmodule

// File: rtl/itlb_nx_top.sv
module itlb_nx_top
  import itlb_nx_pkg::*;
#(
  parameter int WAYS  = 8,
  parameter int SETS  = 8,
  parameter int VA_W  = 48
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       fill_valid,
  input  logic [VA_W-OFF_W-1:0]      fill_vpn,
  input  logic [PTE_W-1:0]           fill_pte,
  output logic                       fill_nopresent,
  input  logic                       fetch_valid,
  input  logic [VA_W-1:0]            fetch_va,
  input  logic                       fetch_user,
  input  logic                       fetch_commit,
  output logic                       xlat_valid,
  output logic                       xlat_hit,
  output logic [PFN_W+OFF_W-1:0]     xlat_pa,
  output logic                       xlat_deny,
  output logic                       xlat_fault,
  output logic [VA_W-1:0]            fault_va
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int IW    = $clog2(SETS);
  localparam int LW    = $clog2(WAYS);
  localparam int TAG_W = VPN_W - IW;
  localparam int PA_W  = PFN_W + OFF_W;

  function automatic logic [LW-1:0] first_one(input logic [WAYS-1:0] v);
    logic [LW-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--) if (v[i]) r = LW'(i);
    return r;
  endfunction

  // Address split
  logic [VPN_W-1:0] rd_vpn;
  logic [IW-1:0]    rd_idx, wr_idx;
  logic [TAG_W-1:0] rd_tag, wr_tag;
  assign rd_vpn = fetch_va[VA_W-1:OFF_W];
  assign rd_idx = rd_vpn[IW-1:0];
  assign rd_tag = rd_vpn[VPN_W-1:IW];
  assign wr_idx = fill_vpn[IW-1:0];
  assign wr_tag = fill_vpn[VPN_W-1:IW];

  // Fill decode
  logic       fill_present;
  itlb_meta_t fill_meta;
  itlb_pte_decode u_dec (.pte(fill_pte), .present(fill_present), .meta(fill_meta));

  logic fill_do;
  assign fill_do = fill_valid && fill_present && !flush;

  // Way array
  logic [WAYS-1:0] hit_vec, match_vec, valid_vec, we_vec;
  itlb_meta_t      way_meta [WAYS];

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      itlb_way_store #(.SETS(SETS), .TAG_W(TAG_W)) u_way (
        .clk(clk), .rst(rst), .flush(flush),
        .we(we_vec[w]), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_meta(fill_meta),
        .rd_idx(rd_idx), .rd_tag(rd_tag),
        .rd_hit(hit_vec[w]), .rd_meta(way_meta[w]),
        .pr_match(match_vec[w]), .pr_valid(valid_vec[w])
      );
    end
  endgenerate

  // Hit merge
  logic          hit_any;
  logic [LW-1:0] hit_way;
  itlb_meta_t    hit_meta;
  always_comb begin
    hit_any  = |hit_vec;
    hit_way  = first_one(hit_vec);
    hit_meta = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_meta = hit_meta | way_meta[w];
  end

  // Replacement: existing tag, then free way, then pseudo-LRU victim
  logic [LW-1:0] plru_victim, fill_way;
  always_comb begin
    if (|match_vec)       fill_way = first_one(match_vec);
    else if (~&valid_vec) fill_way = first_one(~valid_vec);
    else                  fill_way = plru_victim;
    we_vec = '0;
    if (fill_do) we_vec[fill_way] = 1'b1;
  end

  itlb_plru #(.WAYS(WAYS), .SETS(SETS)) u_plru (
    .clk(clk), .rst(rst),
    .hit_en(fetch_valid && hit_any), .hit_idx(rd_idx), .hit_way(hit_way),
    .fill_en(fill_do), .fill_idx(wr_idx), .fill_way(fill_way),
    .victim(plru_victim)
  );

  // Permission evaluation on the stored poison and privilege bits
  logic deny_c, fault_c;
  assign deny_c  = hit_any && (hit_meta.nx_poison || (fetch_user && !hit_meta.user_ok));
  assign fault_c = fetch_valid && fetch_commit && deny_c;

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      xlat_valid     <= 1'b0;
      xlat_hit       <= 1'b0;
      xlat_pa        <= '0;
      xlat_deny      <= 1'b0;
      xlat_fault     <= 1'b0;
      fault_va       <= '0;
      fill_nopresent <= 1'b0;
    end else begin
      xlat_valid     <= fetch_valid;
      xlat_hit       <= fetch_valid && hit_any;
      xlat_pa        <= (fetch_valid && hit_any) ?
                        PA_W'({hit_meta.pfn, fetch_va[OFF_W-1:0]}) : '0;
      xlat_deny      <= fetch_valid && deny_c;
      xlat_fault     <= fault_c;
      fault_va       <= fault_c ? fetch_va : '0;
      fill_nopresent <= fill_valid && !fill_present && !flush;
    end
  end

  assert_rsp_latency_R1: assert property (@(posedge clk) disable iff (rst)
    xlat_valid |-> $past(fetch_valid))
    else $error("response without a request");

  assert_deny_needs_hit_R3: assert property (@(posedge clk) disable iff (rst)
    xlat_deny |-> xlat_hit)
    else $error("deny reported on a miss");

  assert_fault_only_committed_R4: assert property (@(posedge clk) disable iff (rst)
    xlat_fault |-> ($past(fetch_commit) && xlat_deny))
    else $error("fault on a speculative or allowed fetch");

  assert_single_hit_R9: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |-> $onehot0(hit_vec))
    else $error("more than one way hit");

  assert_single_match_R9: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> $onehot0(match_vec))
    else $error("fill matched more than one way");
endmodule

// File: tb/itlb_nx_top_tb_top.sv
module itlb_nx_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        fill_valid = 1'b0;
  logic [35:0] fill_vpn = '0;
  logic [63:0] fill_pte = '0;
  logic        fill_nopresent;
  logic        fetch_valid = 1'b0;
  logic [47:0] fetch_va = '0;
  logic        fetch_user = 1'b0;
  logic        fetch_commit = 1'b0;
  logic        xlat_valid, xlat_hit, xlat_deny, xlat_fault;
  logic [51:0] xlat_pa;
  logic [47:0] fault_va;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  itlb_nx_top dut_i (
    .clk(clk), .rst(rst), .flush(flush),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pte(fill_pte),
    .fill_nopresent(fill_nopresent),
    .fetch_valid(fetch_valid), .fetch_va(fetch_va), .fetch_user(fetch_user),
    .fetch_commit(fetch_commit),
    .xlat_valid(xlat_valid), .xlat_hit(xlat_hit), .xlat_pa(xlat_pa),
    .xlat_deny(xlat_deny), .xlat_fault(xlat_fault), .fault_va(fault_va)
  );

  typedef struct packed {
    logic        hit;
    logic [51:0] pa;
    logic        deny;
    logic        fault;
    logic [47:0] va;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  function automatic logic [63:0] mk_pte(input logic [39:0] pfn, input logic nx,
                                         input logic us, input logic p);
    return {nx, 11'b0, pfn, 9'b0, us, 1'b0, p};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (!rst && xlat_valid) begin
      if (exp_q.size() == 0) begin
        check("R1", "unexpected response", 64'd1, 64'd0);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, "hit", 64'(xlat_hit), 64'(e.hit));
        check(t, "deny", 64'(xlat_deny), 64'(e.deny));
        check(t, "fault", 64'(xlat_fault), 64'(e.fault));
        if (e.hit)   check(t, "pa", 64'(xlat_pa), 64'(e.pa));
        if (e.fault) check(t, "fault_va", 64'(fault_va), 64'(e.va));
      end
    end
  end

  // Driver tasks (inputs change on the falling edge)
  task automatic do_fill(input logic [35:0] vpn, input logic [63:0] pte,
                         input logic with_flush, input logic exp_np, input string req);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_pte = pte; flush = with_flush;
    @(negedge clk);
    fill_valid = 1'b0; flush = 1'b0;
    check(req, "fill_nopresent", 64'(fill_nopresent), 64'(exp_np));
  endtask

  task automatic do_look(input logic [35:0] vpn, input logic [11:0] off,
                         input logic user, input logic commit,
                         input logic e_hit, input logic [39:0] e_pfn,
                         input logic e_deny, input logic e_fault, input string req);
    exp_t e;
    e.hit = e_hit; e.pa = {e_pfn, off}; e.deny = e_deny; e.fault = e_fault;
    e.va  = {vpn, off};
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(req);
    fetch_valid = 1'b1; fetch_va = {vpn, off}; fetch_user = user; fetch_commit = commit;
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    check("R11", "xlat_valid", 64'(xlat_valid), 64'd0);
    check("R11", "xlat_fault", 64'(xlat_fault), 64'd0);
    check("R11", "fill_nopresent", 64'(fill_nopresent), 64'd0);
    do_look(36'h12345, 12'h010, 1'b1, 1'b1, 1'b0, 40'h0, 1'b0, 1'b0, "R11");

    // R1: basic translation
    do_fill(36'h12345, mk_pte(40'hABCDE, 1'b0, 1'b1, 1'b1), 1'b0, 1'b0, "R7");
    do_look(36'h12345, 12'h7F3, 1'b1, 1'b1, 1'b1, 40'hABCDE, 1'b0, 1'b0, "R1");
    // R2: same set, other tag
    do_look(36'h1234D, 12'h000, 1'b1, 1'b1, 1'b0, 40'h0, 1'b0, 1'b0, "R2");

    // R3/R4/R5: no-execute page
    do_fill(36'h00777, mk_pte(40'h00F00, 1'b1, 1'b1, 1'b1), 1'b0, 1'b0, "R3");
    do_look(36'h00777, 12'h123, 1'b1, 1'b0, 1'b1, 40'h00F00, 1'b1, 1'b0, "R4");
    do_look(36'h00777, 12'h456, 1'b1, 1'b1, 1'b1, 40'h00F00, 1'b1, 1'b1, "R5");
    do_look(36'h00777, 12'h004, 1'b0, 1'b1, 1'b1, 40'h00F00, 1'b1, 1'b1, "R3");

    // R6: supervisor page
    do_fill(36'h00042, mk_pte(40'h12121, 1'b0, 1'b0, 1'b1), 1'b0, 1'b0, "R6");
    do_look(36'h00042, 12'hABC, 1'b1, 1'b1, 1'b1, 40'h12121, 1'b1, 1'b1, "R6");
    do_look(36'h00042, 12'hABC, 1'b0, 1'b1, 1'b1, 40'h12121, 1'b0, 1'b0, "R6");

    // R7: not-present fill
    do_fill(36'h00099, mk_pte(40'h55555, 1'b0, 1'b1, 1'b0), 1'b0, 1'b1, "R7");
    do_look(36'h00099, 12'h000, 1'b0, 1'b1, 1'b0, 40'h0, 1'b0, 1'b0, "R7");

    // R9: refill of a held page overwrites it
    do_fill(36'h00777, mk_pte(40'h0BEEF, 1'b0, 1'b1, 1'b1), 1'b0, 1'b0, "R9");
    do_look(36'h00777, 12'h321, 1'b1, 1'b1, 1'b1, 40'h0BEEF, 1'b0, 1'b0, "R9");

    // R8: flush colliding with a fill
    do_fill(36'h00055, mk_pte(40'h00066, 1'b0, 1'b1, 1'b1), 1'b1, 1'b0, "R8");
    do_look(36'h12345, 12'h000, 1'b0, 1'b1, 1'b0, 40'h0, 1'b0, 1'b0, "R8");
    do_look(36'h00042, 12'h000, 1'b0, 1'b1, 1'b0, 40'h0, 1'b0, 1'b0, "R8");
    do_look(36'h00777, 12'h000, 1'b0, 1'b1, 1'b0, 40'h0, 1'b0, 1'b0, "R8");
    do_look(36'h00055, 12'h000, 1'b0, 1'b1, 1'b0, 40'h0, 1'b0, 1'b0, "R8");

    // R10: set 0 fills ways 0..7 in order, then pseudo-LRU victims
    for (int k = 1; k <= 8; k++)
      do_fill(36'(k * 8), mk_pte(40'(256 + k), 1'b0, 1'b1, 1'b1), 1'b0, 1'b0, "R10");
    do_look(36'(64), 12'h000, 1'b0, 1'b1, 1'b1, 40'(264), 1'b0, 1'b0, "R10");
    do_fill(36'(72), mk_pte(40'(265), 1'b0, 1'b1, 1'b1), 1'b0, 1'b0, "R10");
    do_look(36'(8),  12'h000, 1'b0, 1'b1, 1'b0, 40'h0,    1'b0, 1'b0, "R10");
    do_look(36'(16), 12'h000, 1'b0, 1'b1, 1'b1, 40'(258), 1'b0, 1'b0, "R10");
    do_fill(36'(80), mk_pte(40'(266), 1'b0, 1'b1, 1'b1), 1'b0, 1'b0, "R10");
    do_look(36'(40), 12'h000, 1'b0, 1'b1, 1'b0, 40'h0,    1'b0, 1'b0, "R10");
    for (int k = 2; k <= 10; k++)
      if (k != 5)
        do_look(36'(k * 8), 12'h0F0, 1'b0, 1'b1, 1'b1, 40'(256 + k), 1'b0, 1'b0, "R10");

    repeat (4) @(negedge clk);
    check("R1", "pending responses", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule